// File: doc/BRIEF.md
# Port Rate Limiter

This block paces packet starts on a single output port. It keeps a credit accumulator that every packet start charges and that drains at a fixed rate each clock. A registered `send_ok` output tells the upstream scheduler whether the next packet may begin. The charge for one packet is a fixed overhead plus a cost for each 8-byte word. Software supplies three values: the per-packet charge, the per-word charge and a burst limit.

The burst limit is compared with the accumulator in steps of 256 tokens. The same engine therefore covers two uses. With a zero per-word charge it limits packets per second, and the limit is the per-packet charge times the burst count, shifted right by 8. With a per-word charge of 64 tokens-per-bit and a per-packet charge for 24 bytes of framing, it limits bits per second. The framing is 12 bytes of gap, 8 of preamble and 4 of CRC, which the word count leaves out. Those register values are computed outside the block from the clock frequency and the wanted rate.

The block counts every start it is shown, including a start that arrives while `send_ok` is low. Honouring the gate is up to the scheduler.

Top module: `port_rate_limiter`

## Requirements
- R1: A clock edge with `pkt_start` high adds `cfg_pkt_charge + cfg_word_charge * pkt_words` to the accumulator after that edge's drain step.
- R2: With `cfg_word_charge` at 0, every packet costs exactly `cfg_pkt_charge`, whatever its `pkt_words`.
- R3: Each clock edge without clear first lowers the accumulator by the parameter DRAIN and stops at zero. The drain is applied before any charge from the same edge.
- R4: Adding a charge saturates the accumulator at 2^ACC_W-1 and never wraps.
- R5: After each edge, `send_ok` is 0 when (accumulator >> 8) is greater than the `cfg_burst_lim` sampled at that edge, and 1 otherwise. It changes in the same edge as the accumulator, with no extra cycle.
- R6: `clr` high at an edge sets the accumulator to 0 and `send_ok` to 1. It wins over a `pkt_start` at the same edge.
- R7: A change of any configuration input leaves the accumulator unchanged. Only later starts use new charges, and a new limit affects only the comparison.
- R8: While `rst` is high and after it, the accumulator is 0 and `send_ok` is 1.
- R9: A `pkt_start` is charged even when `send_ok` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| clr | input | 1 | Synchronous accumulator clear |
| pkt_start | input | 1 | A packet begins this cycle |
| pkt_words | input | WORDS_W | Packet length in 8-byte words |
| cfg_pkt_charge | input | CHG_W | Tokens charged per packet |
| cfg_word_charge | input | CHG_W | Tokens charged per word |
| cfg_burst_lim | input | LIM_W | Burst limit in units of 256 tokens |
| send_ok | output | 1 | Next packet start is allowed |

## Verification
The accumulator is visible only through `send_ok`. A wrong credit value shows up as a change in how long `send_ok` stays low after a charge. An error of one drain step moves the rising edge by one cycle. A missing saturation or floor shows up as a missing low phase, or one that never ends. The bench compares `send_ok` with a behavioural model on every cycle, so a divergence is reported at the first threshold crossing it affects. Directed cases pick limits and charges that put that crossing at a known cycle count: framing overhead, packet mode, saturation near full scale, and clear racing a start.

// File: rtl/rl_pkg.sv
package rl_pkg;
  // Burst limit granularity: the limit counts units of 2**RL_LIM_SHIFT tokens.
  localparam int unsigned RL_LIM_SHIFT = 8;

  localparam int unsigned RL_DEF_WORDS_W = 14;
  localparam int unsigned RL_DEF_CHG_W   = 16;
  localparam int unsigned RL_DEF_LIM_W   = 24;
  localparam int unsigned RL_DEF_ACC_W   = 32;
  localparam int unsigned RL_DEF_DRAIN   = 16;
endpackage

// File: rtl/rl_charge_calc.sv
module rl_charge_calc #(
  parameter int unsigned WORDS_W = rl_pkg::RL_DEF_WORDS_W,
  parameter int unsigned CHG_W   = rl_pkg::RL_DEF_CHG_W,
  parameter int unsigned ACC_W   = rl_pkg::RL_DEF_ACC_W
) (
  input  logic [WORDS_W-1:0] words,
  input  logic [CHG_W-1:0]   pkt_chg,
  input  logic [CHG_W-1:0]   word_chg,
  output logic [ACC_W-1:0]   charge
);
  localparam int unsigned PROD_W = CHG_W + WORDS_W;
  localparam int unsigned SUM_W  = PROD_W + 1;

  logic [PROD_W-1:0] prod;
  logic [SUM_W-1:0]  sum;

  always_comb begin
    prod = PROD_W'(word_chg) * PROD_W'(words);
    sum  = {1'b0, prod} + SUM_W'(pkt_chg);
  end

  // The width of the full charge against the accumulator picks the variant.
  generate
    if (SUM_W > ACC_W) begin : g_clip
      always_comb begin
        if (|sum[SUM_W-1:ACC_W]) charge = '1;
        else                     charge = sum[ACC_W-1:0];
      end
    end else if (SUM_W == ACC_W) begin : g_pass
      assign charge = sum;
    end else begin : g_ext
      assign charge = {{(ACC_W-SUM_W){1'b0}}, sum};
    end
  endgenerate
endmodule

// File: rtl/rl_credit_acc.sv
module rl_credit_acc #(
  parameter int unsigned ACC_W = rl_pkg::RL_DEF_ACC_W,
  parameter int unsigned DRAIN = rl_pkg::RL_DEF_DRAIN
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clr,
  input  logic             add_en,
  input  logic [ACC_W-1:0] add_val,
  output logic [ACC_W-1:0] credit_q,
  output logic [ACC_W-1:0] credit_nxt
);
  localparam logic [ACC_W-1:0] DRAIN_V = ACC_W'(DRAIN);

  logic [ACC_W-1:0] drained;
  logic [ACC_W:0]   sum;
  logic [ACC_W-1:0] sat_sum;

  always_comb begin
    drained = (credit_q > DRAIN_V) ? credit_q - DRAIN_V : '0;
    sum     = {1'b0, drained} + {1'b0, add_val};
    sat_sum = sum[ACC_W] ? '1 : sum[ACC_W-1:0];
    if (clr)         credit_nxt = '0;
    else if (add_en) credit_nxt = sat_sum;
    else             credit_nxt = drained;
  end

  always_ff @(posedge clk) begin
    if (rst) credit_q <= '0;
    else     credit_q <= credit_nxt;
  end
endmodule

// File: rtl/rl_gate.sv
module rl_gate #(
  parameter int unsigned ACC_W = rl_pkg::RL_DEF_ACC_W,
  parameter int unsigned LIM_W = rl_pkg::RL_DEF_LIM_W
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [ACC_W-1:0] credit_nxt,
  input  logic [LIM_W-1:0] lim,
  output logic             send_ok
);
  localparam int unsigned SH    = rl_pkg::RL_LIM_SHIFT;
  localparam int unsigned LVL_W = ACC_W - SH;
  localparam int unsigned CMP_W = (LVL_W > LIM_W) ? LVL_W : LIM_W;

  logic [LVL_W-1:0] lvl;
  logic             over;

  always_comb begin
    lvl  = credit_nxt[ACC_W-1:SH];
    over = CMP_W'(lvl) > CMP_W'(lim);
  end

  always_ff @(posedge clk) begin
    if (rst) send_ok <= 1'b1;
    else     send_ok <= ~over;
  end
endmodule

// File: rtl/port_rate_limiter.sv
module port_rate_limiter #(
  parameter int unsigned WORDS_W = rl_pkg::RL_DEF_WORDS_W,
  parameter int unsigned CHG_W   = rl_pkg::RL_DEF_CHG_W,
  parameter int unsigned LIM_W   = rl_pkg::RL_DEF_LIM_W,
  parameter int unsigned ACC_W   = rl_pkg::RL_DEF_ACC_W,
  parameter int unsigned DRAIN   = rl_pkg::RL_DEF_DRAIN
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               clr,
  input  logic               pkt_start,
  input  logic [WORDS_W-1:0] pkt_words,
  input  logic [CHG_W-1:0]   cfg_pkt_charge,
  input  logic [CHG_W-1:0]   cfg_word_charge,
  input  logic [LIM_W-1:0]   cfg_burst_lim,
  output logic               send_ok
);
  logic [ACC_W-1:0] charge;
  logic [ACC_W-1:0] credit_q;
  logic [ACC_W-1:0] credit_nxt;

  rl_charge_calc #(.WORDS_W(WORDS_W), .CHG_W(CHG_W), .ACC_W(ACC_W)) u_calc (
    .words    (pkt_words),
    .pkt_chg  (cfg_pkt_charge),
    .word_chg (cfg_word_charge),
    .charge   (charge)
  );

  rl_credit_acc #(.ACC_W(ACC_W), .DRAIN(DRAIN)) u_acc (
    .clk        (clk),
    .rst        (rst),
    .clr        (clr),
    .add_en     (pkt_start),
    .add_val    (charge),
    .credit_q   (credit_q),
    .credit_nxt (credit_nxt)
  );

  rl_gate #(.ACC_W(ACC_W), .LIM_W(LIM_W)) u_gate (
    .clk        (clk),
    .rst        (rst),
    .credit_nxt (credit_nxt),
    .lim        (cfg_burst_lim),
    .send_ok    (send_ok)
  );
endmodule

// File: rtl/rl_checker.sv
module rl_checker #(
  parameter int unsigned LIM_W = rl_pkg::RL_DEF_LIM_W,
  parameter int unsigned ACC_W = rl_pkg::RL_DEF_ACC_W,
  parameter int unsigned DRAIN = rl_pkg::RL_DEF_DRAIN
) (
  input logic             clk,
  input logic             rst,
  input logic             clr,
  input logic             pkt_start,
  input logic [LIM_W-1:0] cfg_burst_lim,
  input logic             send_ok,
  input logic [ACC_W-1:0] credit_q
);
  localparam int unsigned SH    = rl_pkg::RL_LIM_SHIFT;
  localparam int unsigned LVL_W = ACC_W - SH;
  localparam int unsigned CMP_W = (LVL_W > LIM_W) ? LVL_W : LIM_W;
  localparam logic [ACC_W-1:0] DRAIN_V = ACC_W'(DRAIN);

  // R8
  reset_open_chk: assert property (@(posedge clk) rst |=> (send_ok && credit_q == '0));

  // R6
  clear_open_chk: assert property (@(posedge clk) disable iff (rst)
    clr |=> (send_ok && credit_q == '0));

  // R3
  drain_step_chk: assert property (@(posedge clk) disable iff (rst)
    (!clr && !pkt_start && credit_q > DRAIN_V) |=> credit_q == $past(credit_q) - DRAIN_V);

  // R3
  drain_floor_chk: assert property (@(posedge clk) disable iff (rst)
    (!clr && !pkt_start && credit_q <= DRAIN_V) |=> credit_q == '0);

  // R4
  no_wrap_chk: assert property (@(posedge clk) disable iff (rst)
    (!clr && pkt_start) |=>
      credit_q >= (($past(credit_q) > DRAIN_V) ? $past(credit_q) - DRAIN_V : '0));

  // R5
  gate_match_chk: assert property (@(posedge clk) disable iff (rst)
    send_ok == (CMP_W'(credit_q[ACC_W-1:SH]) <= CMP_W'($past(cfg_burst_lim))));
endmodule

bind port_rate_limiter rl_checker #(.LIM_W(LIM_W), .ACC_W(ACC_W), .DRAIN(DRAIN)) chk_i (
  .clk           (clk),
  .rst           (rst),
  .clr           (clr),
  .pkt_start     (pkt_start),
  .cfg_burst_lim (cfg_burst_lim),
  .send_ok       (send_ok),
  .credit_q      (credit_q)
);

// File: tb/port_rate_limiter_tb_top.sv
module port_rate_limiter_tb_top;
  localparam int WORDS_W = 14;
  localparam int CHG_W   = 16;
  localparam int LIM_W   = 24;
  localparam int ACC_W   = 32;
  localparam int DRAIN   = 16;
  localparam longint ACC_MAX = (longint'(1) << ACC_W) - 1;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic               rst = 1'b1;
  logic               clr = 1'b0;
  logic               pkt_start = 1'b0;
  logic [WORDS_W-1:0] pkt_words = '0;
  logic [CHG_W-1:0]   cfg_pkt_charge = '0;
  logic [CHG_W-1:0]   cfg_word_charge = '0;
  logic [LIM_W-1:0]   cfg_burst_lim = '0;
  logic               send_ok;

  port_rate_limiter #(.WORDS_W(WORDS_W), .CHG_W(CHG_W), .LIM_W(LIM_W),
                      .ACC_W(ACC_W), .DRAIN(DRAIN)) dut_i (
    .clk(clk), .rst(rst), .clr(clr), .pkt_start(pkt_start), .pkt_words(pkt_words),
    .cfg_pkt_charge(cfg_pkt_charge), .cfg_word_charge(cfg_word_charge),
    .cfg_burst_lim(cfg_burst_lim), .send_ok(send_ok)
  );

  int  n_run = 0;
  int  n_fail = 0;
  int  cyc = 0;
  bit  done = 1'b0;

  // Behavioural model of the requirements.
  longint ref_acc = 0;
  bit     ref_ok = 1'b1;

  always @(posedge clk) begin : model
    longint a;
    if (rst || clr) begin
      ref_acc = 0;
      ref_ok  = 1'b1;
    end else begin
      a = ref_acc - DRAIN;
      if (a < 0) a = 0;
      if (pkt_start) begin
        a = a + longint'(cfg_pkt_charge) + longint'(cfg_word_charge) * longint'(pkt_words);
        if (a > ACC_MAX) a = ACC_MAX;
      end
      ref_acc = a;
      ref_ok  = (a >> 8) <= longint'(cfg_burst_lim);
    end
  end

  // Per-cycle comparison against the model (R5 and all charge rules behind it).
  always @(negedge clk) begin
    if (!rst && !done) begin
      n_run++;
      if (send_ok !== ref_ok) begin
        n_fail++;
        $display("FAIL R5 model compare cycle %0d: send_ok=%0b expected %0b", cyc, send_ok, ref_ok);
      end
    end
  end

  task automatic finish_run();
    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000 && !done) begin
      n_run++;
      n_fail++;
      $display("FAIL watchdog: cycle %0d expected run end", cyc);
      finish_run();
    end
  end

  task automatic check_bit(string req, logic act, logic exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: got %0b expected %0b", req, act, exp);
    end
  endtask

  task automatic check_int(string req, int act, int exp);
    n_run++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: got %0d expected %0d", req, act, exp);
    end
  endtask

  // Drive a start for n consecutive cycles; returns at the negedge after the last edge.
  task automatic starts(int n, int words);
    @(negedge clk);
    pkt_words = WORDS_W'(words);
    pkt_start = 1'b1;
    for (int i = 0; i < n; i++) @(negedge clk);
    pkt_start = 1'b0;
  endtask

  task automatic count_low(output int n);
    n = 0;
    while (send_ok == 1'b0 && n < 100000) begin
      n++;
      @(negedge clk);
    end
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  int lows;

  initial begin
    idle(3);
    check_bit("R8 send_ok during reset", send_ok, 1'b1);
    rst = 1'b0;
    @(negedge clk);
    check_bit("R8 send_ok after reset", send_ok, 1'b1);

    // R3: drain precedes the charge and floors at zero: 256 lands at exactly 256.
    idle(10);
    cfg_pkt_charge = 16'd256; cfg_word_charge = 16'd0; cfg_burst_lim = '0;
    starts(1, 5);
    check_bit("R3 floor then charge 256 over limit 0", send_ok, 1'b0);
    @(negedge clk);
    check_bit("R3 one drain step reopens", send_ok, 1'b1);

    // R2: packet mode, length has no effect.
    idle(40);
    cfg_pkt_charge = 16'd1024; cfg_burst_lim = 24'd3;
    starts(1, 1);
    check_bit("R2 short packet closes gate", send_ok, 1'b0);
    @(negedge clk);
    check_bit("R2 short packet reopens after one drain", send_ok, 1'b1);
    idle(80);
    starts(1, 16000);
    check_bit("R2 long packet closes gate", send_ok, 1'b0);
    @(negedge clk);
    check_bit("R2 long packet same cost", send_ok, 1'b1);

    // R1: overhead plus per-word cost; 100 + 64*10 = 740 -> low for 31 samples.
    idle(100);
    cfg_pkt_charge = 16'd100; cfg_word_charge = 16'd64; cfg_burst_lim = '0;
    starts(1, 10);
    count_low(lows);
    check_int("R1 low cycles for 740 tokens", lows, 31);
    // R1: word-only charge 8*100 = 800 -> low for 35 samples.
    idle(60);
    cfg_pkt_charge = 16'd0; cfg_word_charge = 16'd8;
    starts(1, 100);
    count_low(lows);
    check_int("R1 low cycles for 800 tokens", lows, 35);

    // R9: starts while closed still charge. 300, 584, 868 with limit 1.
    idle(60);
    cfg_pkt_charge = 16'd300; cfg_word_charge = 16'd0; cfg_burst_lim = 24'd1;
    starts(3, 0);
    count_low(lows);
    check_int("R9 start while closed is charged", lows, 23);

    // R7: configuration changes leave the accumulator alone.
    idle(60);
    cfg_pkt_charge = 16'd0; cfg_word_charge = 16'd64; cfg_burst_lim = '0;
    starts(1, 10);
    check_bit("R7 640 tokens close gate", send_ok, 1'b0);
    cfg_burst_lim = 24'hFFFFFF; cfg_pkt_charge = 16'd5000; cfg_word_charge = 16'd999;
    for (int i = 0; i < 5; i++) begin
      @(negedge clk);
      check_bit("R7 raised limit opens gate", send_ok, 1'b1);
    end
    cfg_burst_lim = '0;
    @(negedge clk);
    check_bit("R7 restored limit closes gate at 544", send_ok, 1'b0);
    count_low(lows);
    check_int("R7 drain continues from 544", lows, 19);

    // R6: clear beats a coincident start.
    idle(20);
    cfg_pkt_charge = 16'd2000; cfg_word_charge = 16'd0; cfg_burst_lim = '0;
    starts(1, 0);
    check_bit("R6 charge closes gate", send_ok, 1'b0);
    clr = 1'b1; pkt_start = 1'b1;
    @(negedge clk);
    clr = 1'b0; pkt_start = 1'b0;
    check_bit("R6 clear opens gate despite start", send_ok, 1'b1);
    @(negedge clk);
    check_bit("R6 accumulator stayed empty", send_ok, 1'b1);

    // R4: saturation at full scale, limit 0xFFFFFE -> 16 closed samples.
    idle(5);
    cfg_pkt_charge = 16'hFFFF; cfg_word_charge = 16'hFFFF; cfg_burst_lim = 24'hFFFFFE;
    starts(3, 16383);
    check_bit("R4 below near-full threshold", send_ok, 1'b1);
    starts(2, 16383);
    count_low(lows);
    check_int("R4 saturated accumulator drains from max", lows, 16);
    @(negedge clk);
    clr = 1'b1;
    @(negedge clk);
    clr = 1'b0;
    cfg_burst_lim = '0;
    @(negedge clk);
    check_bit("R6 clear after saturation", send_ok, 1'b1);

    idle(3);
    finish_run();
  end
endmodule